// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls a 10-bit successive-approximation analog-to-digital converter inside a microcontroller-style peripheral. Software starts a conversion by writing 1 to a start/busy bit. The sequencer then stops the sample-and-hold from tracking the input. On each conversion-clock enable pulse it resolves one bit, from the most significant bit down to the least significant. It drives a trial code to an external DAC and reads back an external comparator.

When the internal RC clock source is selected, the sequencer waits one instruction cycle before the first bit step, so that a sleep request can take effect first. The result register keeps the previous result for the whole conversion. The new result appears in the same clock edge that resolves bit 0. That edge also sets the interrupt flag and clears the busy bit, which software reads as "done". Writing 0 to the start bit during a conversion aborts it.

Top module: `sarSequencer`

## Requirements
- R1: After reset, `busy` is 0, `irqFlag` is 0, `result` is 0 and `sampleEn` is 1.
- R2: A write of 1 to the start bit while idle sets `busy` to 1 and drops `sampleEn` to 0 on the next clock edge. `sampleEn` stays 0 for as long as `busy` is 1.
- R3: A conversion resolves one bit per `convTick` pulse, bit 9 first and bit 0 last, and completes on exactly the 10th accepted pulse. A comparator value of 1 means the input is at or above the trial code, and the trial bit is kept. The final result equals the input code that the comparator models.
- R4: At the start of each step, `dacCode` holds the bits already resolved, a 1 in the bit under trial, and 0 in all lower bits. The first trial code is 10'h200.
- R5: With `rcMode` = 1 at the start write, `convTick` pulses during the first 4 clock cycles after the start (one instruction cycle) are ignored. `dacCode` stays 10'h200 through that window. With `rcMode` = 0, the first pulse after the start is accepted at once.
- R6: `result` keeps its old value while `busy` is 1. On the clock edge that resolves bit 0, `result` takes the new value, `irqFlag` becomes 1 and `busy` becomes 0, so the new result is readable in the next cycle.
- R7: `irqFlag` stays 1 until a cycle with `irqClr` = 1 clears it. When completion and `irqClr` fall in the same cycle, completion wins.
- R8: A write of 0 to the start bit while `busy` is 1 aborts the conversion on the next edge: `busy` goes to 0, `sampleEn` goes to 1, `result` keeps its value and `irqFlag` is not set.
- R9: A write of 1 to the start bit while `busy` is 1 has no effect, and the conversion finishes with the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convTick | input | 1 | Conversion-clock enable, one pulse per bit period |
| rcMode | input | 1 | 1 selects the internal RC conversion clock (adds the start delay) |
| startWrEn | input | 1 | Software write strobe for the start bit |
| startWrData | input | 1 | Value written to the start bit |
| irqClr | input | 1 | Software clear of the interrupt flag |
| compIn | input | 1 | Comparator output, 1 when the input is at or above `dacCode` |
| dacCode | output | 10 | Trial code to the DAC |
| sampleEn | output | 1 | 1 while the sample-and-hold tracks the input |
| result | output | 10 | Result register |
| irqFlag | output | 1 | Conversion-complete interrupt flag |
| busy | output | 1 | Start/busy bit read-back |

## Verification
The bench targets several corner cases, each with a distinct failure symptom:
- Extreme input codes 0 and 1023, and alternating bit patterns. A wrong bit order or a wrong keep/clear decision gives a wrong final code.
- Pulses inside the RC start window. A sequencer that missed the window would change the trial code too early.
- The result register read during a conversion. A design that updated `result` early would show part of a new code.
- An abort after a few steps, a second start write during a conversion, and an interrupt clear in the same cycle as completion. A faulty design would raise a false interrupt, corrupt the held result, restart the conversion, or lose the done flag.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_CONV  = 2'd2
  } seqState_e;

  typedef struct packed {
    logic startLoad;
    logic decide;
    logic commit;
  } seqStrobes_t;
endpackage

// File: rtl/sarDatapath.sv
module sarDatapath
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  localparam int IDX_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                compIn,
  output logic [RES_BITS-1:0] codeOut,
  output logic [RES_BITS-1:0] resultOut
);
  logic [RES_BITS-1:0] codeQ;
  logic [RES_BITS-1:0] resolved;
  logic [RES_BITS-1:0] nextTrial;

  always_comb begin
    resolved = codeQ;
    resolved[bitIdx] = compIn;
  end

  generate
    for (genvar i = 0; i < RES_BITS; i++) begin : g_trial
      assign nextTrial[i] = (int'(bitIdx) - 1) == i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ     <= '0;
      resultOut <= '0;
    end else begin
      if (strobes.startLoad) begin
        codeQ <= {1'b1, {(RES_BITS-1){1'b0}}};
      end else if (strobes.decide) begin
        codeQ <= resolved | nextTrial;
      end
      if (strobes.commit) begin
        resultOut <= resolved;
      end
    end
  end

  assign codeOut = codeQ;
endmodule

// File: rtl/sarControl.sv
module sarControl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int INSTR_CLKS = 4,
  localparam int IDX_W = $clog2(RES_BITS),
  localparam int CNT_W = (INSTR_CLKS > 1) ? $clog2(INSTR_CLKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convTick,
  input  logic             rcMode,
  input  logic             startWrEn,
  input  logic             startWrData,
  input  logic             irqClr,
  output seqStrobes_t      strobes,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy,
  output logic             irqFlag,
  output logic             sampleEn
);
  seqState_e stateQ;
  logic [CNT_W-1:0] waitCnt;
  logic startReq, abortReq, stepNow, lastStep;

  assign startReq = startWrEn && startWrData && (stateQ == ST_IDLE);
  assign abortReq = startWrEn && !startWrData && (stateQ != ST_IDLE);
  assign stepNow  = (stateQ == ST_CONV) && convTick && !abortReq;
  assign lastStep = stepNow && (bitIdx == '0);

  always_comb begin
    strobes.startLoad = startReq;
    strobes.decide    = stepNow;
    strobes.commit    = lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      waitCnt <= '0;
      bitIdx  <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (lastStep) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;

      if (abortReq) begin
        stateQ <= ST_IDLE;
      end else begin
        case (stateQ)
          ST_IDLE: if (startReq) begin
            stateQ  <= rcMode ? ST_DELAY : ST_CONV;
            waitCnt <= '0;
            bitIdx  <= IDX_W'(RES_BITS - 1);
          end
          ST_DELAY: begin
            if (waitCnt == CNT_W'(INSTR_CLKS - 1)) stateQ <= ST_CONV;
            else waitCnt <= waitCnt + 1'b1;
          end
          ST_CONV: if (stepNow) begin
            if (lastStep) stateQ <= ST_IDLE;
            else bitIdx <= bitIdx - 1'b1;
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy     = (stateQ != ST_IDLE);
  assign sampleEn = (stateQ == ST_IDLE);
endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int INSTR_CLKS = 4,
  localparam int IDX_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convTick,
  input  logic                rcMode,
  input  logic                startWrEn,
  input  logic                startWrData,
  input  logic                irqClr,
  input  logic                compIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic                sampleEn,
  output logic [RES_BITS-1:0] result,
  output logic                irqFlag,
  output logic                busy
);
  seqStrobes_t strobes;
  logic [IDX_W-1:0] bitIdx;

  sarControl #(.RES_BITS(RES_BITS), .INSTR_CLKS(INSTR_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .convTick(convTick), .rcMode(rcMode),
    .startWrEn(startWrEn), .startWrData(startWrData), .irqClr(irqClr),
    .strobes(strobes), .bitIdx(bitIdx), .busy(busy), .irqFlag(irqFlag),
    .sampleEn(sampleEn)
  );

  sarDatapath #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx),
    .compIn(compIn), .codeOut(dacCode), .resultOut(result)
  );
endmodule

// File: rtl/sarSequencerChk.sv
module sarSequencerChk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                startWrEn,
  input logic                startWrData,
  input logic                irqClr,
  input logic                sampleEn,
  input logic [RES_BITS-1:0] result,
  input logic                irqFlag,
  input logic                busy
);
  p_no_sample_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sampleEn);

  p_result_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(result));

  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(startWrEn)) |-> irqFlag);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startWrEn && !startWrData) |=> (!busy && $stable(result)));
endmodule

bind sarSequencer sarSequencerChk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .startWrEn(startWrEn), .startWrData(startWrData),
  .irqClr(irqClr), .sampleEn(sampleEn), .result(result),
  .irqFlag(irqFlag), .busy(busy)
);

// File: tb/tb_sarSequencer.sv
`timescale 1ns/1ps
module tb_sarSequencer;
  localparam int W = 10;
  localparam int IC = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic convTick = 0, rcMode = 0, startWrEn = 0, startWrData = 0, irqClr = 0;
  logic [W-1:0] vin = '0;
  logic compIn;
  logic [W-1:0] dacCode, result;
  logic sampleEn, irqFlag, busy;

  int errors = 0, checks = 0;
  logic [W-1:0] expQ[$];
  logic irqPrev = 1'b0;

  always #4 clk = ~clk;
  assign compIn = (vin >= dacCode);

  sarSequencer #(.RES_BITS(W), .INSTR_CLKS(IC)) dut (
    .clk(clk), .rstN(rstN), .convTick(convTick), .rcMode(rcMode),
    .startWrEn(startWrEn), .startWrData(startWrData), .irqClr(irqClr),
    .compIn(compIn), .dacCode(dacCode), .sampleEn(sampleEn),
    .result(result), .irqFlag(irqFlag), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected result on each rising interrupt
  always @(negedge clk) begin
    if (rstN && irqFlag && !irqPrev) begin
      if (expQ.size() == 0) check("R8 unexpected irq", 1, 0);
      else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        check("R3 result", int'(result), int'(e));
        check("R6 busy clear at done", int'(busy), 0);
      end
    end
    irqPrev <= irqFlag;
  end

  task automatic writeStart(input logic val);
    startWrEn = 1; startWrData = val;
    @(negedge clk);
    startWrEn = 0; startWrData = 0;
  endtask

  task automatic tick();
    convTick = 1;
    @(negedge clk);
    convTick = 0;
  endtask

  task automatic clearIrq();
    irqClr = 1;
    @(negedge clk);
    irqClr = 0;
  endtask

  // driver: full conversion, pushes expected result
  task automatic runConv(input logic [W-1:0] v, input logic rc, input logic restartMid);
    logic [W-1:0] old;
    old = result;
    vin = v; rcMode = rc;
    expQ.push_back(v);
    writeStart(1'b1);
    check("R2 busy after start", int'(busy), 1);
    check("R2 sampleEn low", int'(sampleEn), 0);
    if (rc) repeat (IC) @(negedge clk);
    for (int k = 0; k < W; k++) begin
      if (k == 5 && restartMid) writeStart(1'b1);
      if (k < W - 1) begin
        tick();
        check("R6 result held", int'(result), int'(old));
        @(negedge clk);
      end else begin
        tick();
      end
    end
    check("R6 irq set", int'(irqFlag), 1);
    clearIrq();
    check("R7 irq cleared", int'(irqFlag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 irq", int'(irqFlag), 0);
    check("R1 result", int'(result), 0);
    check("R1 sampleEn", int'(sampleEn), 1);
    rstN = 1;
    @(negedge clk);

    runConv(10'h3FF, 0, 0);
    runConv(10'h000, 0, 0);
    runConv(10'h2AA, 0, 0);
    runConv(10'h155, 1, 0);

    // R4: trial codes step by step for vin=0x2C5
    vin = 10'h2C5; rcMode = 0;
    writeStart(1'b1);
    check("R4 first trial", int'(dacCode), 10'h200);
    tick();
    check("R4 trial after bit9", int'(dacCode), 10'h300);
    tick();
    check("R4 trial after bit8", int'(dacCode), 10'h280);
    writeStart(1'b0);
    check("R8 abort busy", int'(busy), 0);
    check("R8 abort sampleEn", int'(sampleEn), 1);
    check("R8 result kept", int'(result), 10'h155);
    repeat (3) @(negedge clk);
    check("R8 no irq", int'(irqFlag), 0);

    // R5: ticks in RC delay window ignored
    vin = 10'h000; rcMode = 1;
    writeStart(1'b1);
    for (int i = 0; i < IC; i++) tick();
    check("R5 dac held during delay", int'(dacCode), 10'h200);
    tick();
    check("R5 first step after delay", int'(dacCode), 10'h100);
    writeStart(1'b0);
    // R5: non-RC accepts first tick immediately
    rcMode = 0;
    writeStart(1'b1);
    tick();
    check("R5 non-rc immediate step", int'(dacCode), 10'h100);
    writeStart(1'b0);

    // R9: restart write mid-conversion ignored
    runConv(10'h1E7, 0, 1);
    check("R9 result unaffected", int'(result), 10'h1E7);

    // R7: completion wins over same-cycle clear, flag sticky
    vin = 10'h0F0; rcMode = 0;
    expQ.push_back(10'h0F0);
    writeStart(1'b1);
    for (int k = 0; k < W - 1; k++) tick();
    irqClr = 1; convTick = 1;
    @(negedge clk);
    irqClr = 0; convTick = 0;
    check("R7 set wins over clear", int'(irqFlag), 1);
    repeat (5) @(negedge clk);
    check("R7 irq sticky", int'(irqFlag), 1);
    check("R6 new result readable", int'(result), 10'h0F0);
    clearIrq();
    check("R7 cleared", int'(irqFlag), 0);
    check("R3 queue drained", expQ.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule